// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of an 8-bit successive-approximation analog-to-digital converter. It drives the trial code that feeds an external resistor ladder, reads back a single comparator decision each bit period, and settles the code from the most significant bit down. A host talks to it through three active-low strobes: select, start and read. It reports completion on an active-low interrupt line.

Pulling select and start low together forces the sequencer into a reset hold. Releasing either strobe arms a conversion. The conversion begins at the next boundary of a free-running divide-by-8 phase counter, so the start delay is between one and eight clocks. Each bit then takes exactly eight clocks. Only a finished conversion updates the result register. If the host restarts in the middle of a conversion, that conversion is abandoned and the previous result is kept. The read strobe, qualified by select, raises the output-enable flag and clears the interrupt.

All three strobes pass through a two-flop synchroniser. The reset input is asserted asynchronously and is released through its own two-flop synchroniser.

Top module: `sar_ctrl`

## Requirements
- R1: During reset and right after it, trial_code and result are 0, busy and result_oe are 0, and intr_n is 1.
- R2: The strobes are seen through two synchronising flops. result_oe goes to 1 in the second clock after cs_n and rd_n are both driven low, not in the first, and it stays 1 exactly while both synchronised values are low.
- R3: While the synchronised cs_n and wr_n are both 0, the sequencer is held. From the next clock on, trial_code is 0, busy is 0 and intr_n is 1, even if a finished result was never read.
- R4: After the hold is released, busy rises on a phase-counter boundary. Counting from the clock edge after the pin is released, this happens 4 to 11 clocks later. Across different release phases, all eight delays occur.
- R5: During a conversion, trial_code changes only every 8 clocks. In each bit period it holds the decided upper bits, a 1 in the bit under test, and zeros below.
- R6: At the last clock of a bit period, the bit under test is kept when cmp_hi is 1 and cleared when cmp_hi is 0. The final code therefore equals the largest code not above the comparator threshold.
- R7: In the clock after the eighth decision, result holds the decided code, intr_n is 0 and busy is 0.
- R8: A synchronised read (cs_n and rd_n both 0) sets intr_n to 1 on the next clock, unless a conversion finishes in that same clock. A finishing conversion wins, so with read held low continuously intr_n is low for exactly one clock.
- R9: A hold applied during a conversion stops it within one clock. result keeps the last completed code until a later conversion finishes.
- R10: From the release of the start strobe, counted as in R4, intr_n falls 68 to 75 clocks later.
- R11: busy is 1 from the end of the start delay until the result is latched, and trial_code is nonzero whenever busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Active-low select strobe |
| wr_n | input | 1 | Active-low start strobe |
| rd_n | input | 1 | Active-low read strobe |
| cmp_hi | input | 1 | Comparator decision: 1 when the analog input is at or above the trial level |
| trial_code | output | 8 | Code driven to the ladder |
| busy | output | 1 | High while bits are being decided |
| result | output | 8 | Last completed conversion code |
| result_oe | output | 1 | Enable for the result bus, high while a read is active |
| intr_n | output | 1 | Active-low conversion-complete interrupt |

## Verification
The assertions check the following on every cycle: a hold empties the sequencer and raises the interrupt, a busy rise falls on phase zero, the trial code stays put inside a bit period, each decision is copied into the trial code, completion latches the code and drops the interrupt, a read raises the interrupt, and the result changes only on completion. Only the bench scenarios can show the things that need a whole conversion or an analog input. These are the full code against a modelled comparator threshold, all eight start delays, the total conversion time, the survival of the old result across an aborted conversion, and the one-clock interrupt pulse under a read held low. A behavioural model in the bench predicts every output on every clock.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2,
    ST_CONV = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int   N       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [STAGES-1:0][N-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= {(STAGES*N){RST_VAL}};
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int PH_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] done_code
);
  localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [PH_BITS-1:0] PH_LAST = {PH_BITS{1'b1}};
  localparam logic [IDX_W-1:0]   IDX_TOP = IDX_W'(WIDTH - 1);
  localparam logic [WIDTH-1:0]   TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e         state_q, state_d;
  logic [PH_BITS-1:0] phase_q, phase_d;
  logic [WIDTH-1:0]   sar_q, sar_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [WIDTH-1:0]   decided;
  logic               last_ph;

  assign last_ph = (phase_q == PH_LAST);

  always_comb begin
    state_d  = state_q;
    sar_d    = sar_q;
    idx_d    = idx_q;
    phase_d  = phase_q + 1'b1;
    done     = 1'b0;
    decided  = sar_q;
    decided[idx_q] = cmp_hi;
    if (hold) begin
      state_d = ST_HOLD;
      sar_d   = '0;
      idx_d   = IDX_TOP;
    end else begin
      case (state_q)
        ST_HOLD: state_d = ST_WAIT;
        ST_WAIT: begin
          if (last_ph) begin
            state_d = ST_CONV;
            sar_d   = TOP_BIT;
            idx_d   = IDX_TOP;
          end
        end
        ST_CONV: begin
          if (last_ph) begin
            if (idx_q == '0) begin
              done    = 1'b1;
              state_d = ST_IDLE;
              sar_d   = '0;
            end else begin
              sar_d            = decided;
              sar_d[idx_q - 1'b1] = 1'b1;
              idx_d            = idx_q - 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      sar_q   <= '0;
      idx_q   <= IDX_TOP;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      sar_q   <= sar_d;
      idx_q   <= idx_d;
    end
  end

  assign trial_code = sar_q;
  assign busy       = (state_q == ST_CONV);
  assign done_code  = decided;

  a_r3_hold_empties: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!busy && trial_code == '0));
  a_r4_start_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase_q == '0));
  a_r5_trial_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold && !last_ph) |=> $stable(trial_code));
  a_r6_decision_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hold && last_ph && idx_q != '0) |=>
      (trial_code[$past(idx_q)] == $past(cmp_hi)));
  a_r11_busy_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (trial_code != '0));
endmodule

// File: rtl/sar_out.sv
module sar_out #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             read,
  input  logic             done,
  input  logic [WIDTH-1:0] done_code,
  output logic [WIDTH-1:0] result,
  output logic             intr_n
);
  logic [WIDTH-1:0] result_q;
  logic             intr_q, intr_d;
  logic             res_en;

  assign res_en = done;

  always_comb begin
    intr_d = intr_q;
    if (hold)      intr_d = 1'b1;
    else if (done) intr_d = 1'b0;
    else if (read) intr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
      intr_q   <= 1'b1;
    end else begin
      if (res_en) result_q <= done_code;
      intr_q <= intr_d;
    end
  end

  assign result = result_q;
  assign intr_n = intr_q;

  a_r7_done_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!intr_n && result == $past(done_code)));
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (read && !done && !hold) |=> intr_n);
  a_r9_result_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(result));
  a_r3_hold_intr: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> intr_n);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PH_BITS     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             cmp_hi,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy,
  output logic [WIDTH-1:0] result,
  output logic             result_oe,
  output logic             intr_n
);
  localparam int NSTROBE = 3;

  logic               rst_int_n;
  logic [NSTROBE-1:0] strobe_s;
  logic               cs_s, wr_s, rd_s;
  logic               hold, read;
  logic               done;
  logic [WIDTH-1:0]   done_code;

  sar_sync #(.N(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_int_n)
  );

  sar_sync #(.N(NSTROBE), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     ({cs_n, wr_n, rd_n}),
    .q     (strobe_s)
  );

  assign cs_s = strobe_s[2];
  assign wr_s = strobe_s[1];
  assign rd_s = strobe_s[0];
  assign hold = ~cs_s & ~wr_s;
  assign read = ~cs_s & ~rd_s;
  assign result_oe = read;

  sar_seq #(.WIDTH(WIDTH), .PH_BITS(PH_BITS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hold       (hold),
    .cmp_hi     (cmp_hi),
    .trial_code (trial_code),
    .busy       (busy),
    .done       (done),
    .done_code  (done_code)
  );

  sar_out #(.WIDTH(WIDTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .hold      (hold),
    .read      (read),
    .done      (done),
    .done_code (done_code),
    .result    (result),
    .intr_n    (intr_n)
  );

  a_r2_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_int_n)
    result_oe |-> (!cs_s && !rd_s));
endmodule

// File: tb/test_sar_ctrl.sv
module test_sar_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, rd_n;
  logic [7:0] vin;
  logic       cmp_hi;
  logic [7:0] trial_code, result;
  logic       busy, result_oe, intr_n;

  int tests = 0;
  int fails = 0;
  int wd    = 0;
  bit cmp_en = 1'b0;

  always #10 clk = ~clk;

  assign cmp_hi = (vin >= trial_code);

  sar_ctrl i_sar_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .cmp_hi(cmp_hi), .trial_code(trial_code), .busy(busy),
    .result(result), .result_oe(result_oe), .intr_n(intr_n)
  );

  // behavioural reference: 0 idle, 1 hold, 2 wait, 3 converting
  int         m_st, m_idx, m_phase, m_rc;
  logic [7:0] m_sar, m_res;
  logic       m_intr, m_done, m_hold, m_read, m_bit;
  logic       m_cs1, m_cs2, m_wr1, m_wr2, m_rd1, m_rd2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_idx = 7; m_phase = 0; m_rc = 0;
      m_sar = 8'h00; m_res = 8'h00; m_intr = 1'b1;
      m_cs1 = 1; m_cs2 = 1; m_wr1 = 1; m_wr2 = 1; m_rd1 = 1; m_rd2 = 1;
    end else if (m_rc < 2) begin
      m_rc = m_rc + 1;
    end else begin
      m_hold = !m_cs2 && !m_wr2;
      m_read = !m_cs2 && !m_rd2;
      m_done = 1'b0;
      if (m_hold) begin
        m_st = 1; m_sar = 8'h00; m_idx = 7;
      end else if (m_st == 1) begin
        m_st = 2;
      end else if (m_st == 2) begin
        if (m_phase == 7) begin m_st = 3; m_sar = 8'h80; m_idx = 7; end
      end else if (m_st == 3 && m_phase == 7) begin
        m_bit = (vin >= m_sar);
        m_sar[m_idx] = m_bit;
        if (m_idx == 0) begin
          m_res = m_sar; m_done = 1'b1; m_st = 0; m_sar = 8'h00;
        end else begin
          m_sar[m_idx-1] = 1'b1;
          m_idx = m_idx - 1;
        end
      end
      if (m_hold) m_intr = 1'b1;
      else if (m_done) m_intr = 1'b0;
      else if (m_read) m_intr = 1'b1;
      m_phase = (m_phase + 1) % 8;
      m_cs2 = m_cs1; m_wr2 = m_wr1; m_rd2 = m_rd1;
      m_cs1 = cs_n;  m_wr1 = wr_n;  m_rd1 = rd_n;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      tests++;
      if (trial_code !== m_sar) begin
        fails++; $display("FAIL R5 trial_code act=%h exp=%h", trial_code, m_sar);
      end
      if (result !== m_res) begin
        fails++; $display("FAIL R7 result act=%h exp=%h", result, m_res);
      end
      if (intr_n !== m_intr) begin
        fails++; $display("FAIL R8 intr_n act=%b exp=%b", intr_n, m_intr);
      end
      if (busy !== (m_st == 3)) begin
        fails++; $display("FAIL R11 busy act=%b exp=%b", busy, (m_st == 3));
      end
      if (result_oe !== (!m_cs2 && !m_rd2)) begin
        fails++; $display("FAIL R2 result_oe act=%b exp=%b", result_oe, (!m_cs2 && !m_rd2));
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold, then release aligned to reference phase; returns delays
  task automatic start_conv(input int align, output int d_busy, output int d_intr);
    int n;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    cycles(4);
    chk(busy == 1'b0 && trial_code == 8'h00, "R3 hold empties", busy, 0);
    chk(intr_n == 1'b1, "R3 hold raises intr_n", intr_n, 1);
    for (int i = 0; i < 16 && m_phase != align; i++) @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    n = 0; d_busy = 0; d_intr = 0;
    for (int i = 0; i < 100 && intr_n; i++) begin
      @(negedge clk); n++;
      if (busy && d_busy == 0) d_busy = n;
      if (!intr_n) d_intr = n;
    end
  endtask

  task automatic do_read(input logic [7:0] exp);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    chk(result_oe == 1'b0, "R2 oe not after one clock", result_oe, 0);
    @(negedge clk);
    chk(result_oe == 1'b1, "R2 oe after two clocks", result_oe, 1);
    @(negedge clk);
    chk(intr_n == 1'b1, "R8 read clears intr_n", intr_n, 1);
    chk(result == exp, "R6 result code", result, exp);
    cs_n = 1'b1; rd_n = 1'b1;
    cycles(3);
  endtask

  initial begin
    int db, di, mask, lowcnt;
    logic [7:0] vals [10];
    vals = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h7F, 8'h01, 8'hFE, 8'h3C, 8'hC3};
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; vin = 8'h00;
    cycles(3);
    chk(intr_n == 1 && busy == 0 && trial_code == 0 && result == 0 && result_oe == 0,
        "R1 in reset", {intr_n, busy, result_oe}, 3'b100);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    cycles(4);
    chk(intr_n == 1 && busy == 0 && trial_code == 0 && result == 0 && result_oe == 0,
        "R1 after reset", {intr_n, busy, result_oe}, 3'b100);

    // all eight start phases, varied codes
    mask = 0;
    for (int j = 0; j < 10; j++) begin
      vin = vals[j];
      start_conv(j % 8, db, di);
      chk(db >= 4 && db <= 11, "R4 start delay range", db, 4);
      chk(di >= 68 && di <= 75, "R10 total time range", di, 68);
      chk(di - db == 64, "R5 eight clocks per bit", di - db, 64);
      chk(intr_n == 1'b0 && busy == 1'b0, "R7 done state", intr_n, 0);
      chk(result == vals[j], "R7 latched code", result, vals[j]);
      if (db >= 4 && db <= 11) mask = mask | (1 << (db - 4));
      if (j != 3) do_read(vals[j]);
    end
    chk(mask == 8'hFF, "R4 all eight delays seen", mask, 255);

    // abort: result from the last finished conversion must survive
    vin = 8'h3C;
    start_conv(0, db, di);
    do_read(8'h3C);
    vin = 8'hE1;
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    cycles(4);
    cs_n = 1'b1; wr_n = 1'b1;
    for (int i = 0; i < 40 && !busy; i++) @(negedge clk);
    cycles(30);
    chk(busy == 1'b1, "R11 busy mid conversion", busy, 1);
    cs_n = 1'b0; wr_n = 1'b0;
    cycles(4);
    chk(busy == 1'b0, "R9 abort stops", busy, 0);
    chk(result == 8'h3C, "R9 old result kept", result, 8'h3C);
    cs_n = 1'b1; wr_n = 1'b1;
    for (int i = 0; i < 100 && intr_n; i++) @(negedge clk);
    chk(result == 8'hE1, "R9 next conversion completes", result, 8'hE1);
    do_read(8'hE1);

    // read held low: interrupt pulses for one clock
    vin = 8'h96;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; wr_n = 1'b0;
    cycles(4);
    wr_n = 1'b1;
    lowcnt = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (!intr_n) lowcnt++;
    end
    chk(lowcnt == 1, "R8 done wins over read", lowcnt, 1);
    chk(result == 8'h96 && result_oe == 1'b1, "R6 continuous read code", result, 8'h96);
    cs_n = 1'b1; rd_n = 1'b1;
    cycles(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=%0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule